// File: doc/BRIEF.md
# Stereo Sample FIFO with Per-Phase Thresholds

This block sits between a register-strobe bus port (or a DMA engine using the same port) and an audio serializer. Each direction has one data address on the bus that carries left and right samples in strict alternation. Behind that address the block keeps four separate queues: transmit-left, transmit-right, receive-left and receive-right. A steering bit per direction decides which queue the next bus access uses. It starts at left after reset or after a flush, and it moves on only when the access actually moves a sample.

The serializer side names the phase explicitly. It pops transmit samples from the left or right queue and pushes received samples into either one. Each queue has its own 3-bit threshold code. A transmit queue raises its empty-level condition when it has at least that much free space. A receive queue raises its full-level condition when it holds at least that many samples. Together with underrun and overrun events, these conditions feed eight sticky flags. The flags are cleared by writing 1, each has its own mask bit, and they combine into one interrupt line. For each direction, a DMA request is raised while that direction's DMA enable is set and either of its two level conditions holds.

Register offsets on `bus_addr`: 0 control, 1 status, 2 flags, 3 mask, 4 transmit data, 5 receive data. Read data is combinational from the current state. A read strobe on offset 5 removes the sample it shows.

Top module: `stereo_sample_fifo`

## Requirements
- R1: After reset every queue is empty, the control and mask registers read 0, the status register reads 0x00000003, and `irq` and both DMA requests are low.
- R2: Accepted writes to offset 4 go alternately to transmit-left and transmit-right, starting with left. The serializer pops from the queue chosen by `ser_tx_phase` (0 = left, 1 = right), in write order.
- R3: A write to offset 4 whose target queue is full is dropped and does not advance the transmit steering bit. The queue count never exceeds DEPTH.
- R4: Reads of offset 5 take samples alternately from receive-left and receive-right, starting with left. A read whose target queue is empty returns 0, removes nothing and does not advance the steering bit.
- R5: Threshold codes 0, 1, 2 and 3 mean 2, 4, 8 and 16 words; codes 4 to 7 also mean 16. A transmit queue's empty-level condition holds while its free space is at least the threshold. A receive queue's full-level condition holds while its occupancy is at least the threshold.
- R6: A serializer pop from an empty transmit queue sets that phase's underrun flag and presents 0 on `ser_tx_data`. A serializer push into a full receive queue sets that phase's overrun flag and drops the sample.
- R7: Flag bits at offset 2 are: 0 tx-left level, 1 tx-right level, 2 tx-left underrun, 3 tx-right underrun, 4 rx-left level, 5 rx-right level, 6 rx-left overrun, 7 rx-right overrun. Writing 1 clears a bit, but a new event in the same cycle wins. `irq` is high while any flag has its mask bit (offset 3, same positions) set.
- R8: Status bit 17 is transmit-left full, bit 16 transmit-right full, bit 1 receive-left empty, bit 0 receive-right empty. All other bits read 0.
- R9: Writing control bit 20 flushes both transmit queues, and writing control bit 21 flushes both receive queues. A flush also returns that direction's steering to left. Both bits read back as 0.
- R10: `tx_dma_req` is high while control bit 16 is set and either transmit empty-level condition holds. `rx_dma_req` is high while control bit 17 is set and either receive full-level condition holds.
- R11: Reading offset 4 returns the most recent accepted transmit sample, zero-extended, and 0 after reset.
- R12: Control threshold codes are at bits [2:0] tx-left, [6:4] tx-right, [10:8] rx-left and [14:12] rx-right. They read back as written, and all unlisted control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for `bus_addr` |
| ser_tx_pop | input | 1 | Serializer takes one transmit sample |
| ser_tx_phase | input | 1 | Phase for pop and for `ser_tx_data`, 0 = left |
| ser_tx_data | output | SW | Head of the selected transmit queue, 0 when empty |
| ser_rx_push | input | 1 | Serializer delivers one received sample |
| ser_rx_phase | input | 1 | Phase of the received sample, 0 = left |
| ser_rx_data | input | SW | Received sample |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Masked OR of the flags |

## Verification
On every cycle, the assertions check several queue and steering rules. Queue bounds hold. Dropped accesses leave the count and the steering bit unchanged. Accepted accesses flip the steering bit. Flushes empty the queue and return steering to left. A set event always lands in its flag, and a write-one-clear takes effect when no event competes. Some behaviours only the directed scenarios can show. These are the end-to-end order of samples through the alternation, the exact threshold boundary for each code, the register bit positions, the readback of the last transmit sample, and the DMA and interrupt outputs under chosen enables and masks.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_FLAGS  = 3'd2;
  localparam logic [2:0] OFS_MASK   = 3'd3;
  localparam logic [2:0] OFS_TXDAT  = 3'd4;
  localparam logic [2:0] OFS_RXDAT  = 3'd5;

  // queue indices: transmit pair first, then receive pair; bit 0 is the phase
  localparam int Q_TXL = 0;
  localparam int Q_TXR = 1;
  localparam int Q_RXL = 2;
  localparam int Q_RXR = 3;
  localparam int NQ    = 4;
  localparam int NFLAG = 8;

  localparam int THR_W = 3;
  localparam int CTL_TXDMA = 16;
  localparam int CTL_RXDMA = 17;
  localparam int CTL_TXCLR = 20;
  localparam int CTL_RXCLR = 21;

  // threshold code to word count; codes above 3 saturate at 16
  function automatic logic [15:0] thr_words(input logic [THR_W-1:0] code);
    logic [15:0] w;
    if (code[2] || code[1:0] == 2'd3) w = 16'd16;
    else w = 16'd2 << code[1:0];
    return w;
  endfunction

endpackage

// File: rtl/ssf_lane.sv
module ssf_lane import ssf_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int SW    = 24,
  parameter bit IS_TX = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 push,
  input  logic [SW-1:0]        push_data,
  input  logic                 pop,
  input  logic [THR_W-1:0]     thr_code,
  output logic [SW-1:0]        head,
  output logic                 full,
  output logic                 empty,
  output logic                 level,
  output logic                 push_drop,
  output logic                 pop_miss
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;
  logic [15:0]   occ, space, thr;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign push_drop = push && full && !clear;
  assign pop_miss  = pop && empty && !clear;
  assign head    = empty ? '0 : mem[rd_ptr];

  assign occ   = 16'(count);
  assign space = 16'(DEPTH) - occ;
  assign thr   = thr_words(thr_code);

  generate
    if (IS_TX) begin : g_tx_level
      assign level = (space >= thr);
    end else begin : g_rx_level
      assign level = (occ >= thr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r3_drop_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop) |=> $stable(count));

  a_r4_miss_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_miss && !push) |=> $stable(count));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);

endmodule

// File: rtl/ssf_steer.sv
module ssf_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= 1'b0;
    else if (clear)   phase <= 1'b0;
    else if (advance) phase <= ~phase;
  end

  a_r2_accept_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> (phase != $past(phase)));

  a_r9_clear_to_left: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !phase);

endmodule

// File: rtl/ssf_flags.sv
module ssf_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         w1c_en,
  input  logic [N-1:0] w1c,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_data,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] clr_bits;
  assign clr_bits = w1c_en ? w1c : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (flags & ~clr_bits) | set_evt;
      if (mask_wr) mask <= mask_data;
    end
  end

  assign irq = |(flags & mask);

  generate
    for (genvar k = 0; k < N; k++) begin : g_chk
      a_r6_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[k] |=> flags[k]);
      a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits[k] && !set_evt[k]) |=> !flags[k]);
    end
  endgenerate

endmodule

// File: rtl/stereo_sample_fifo.sv
module stereo_sample_fifo import ssf_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int SW    = 24,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ser_tx_pop,
  input  logic             ser_tx_phase,
  output logic [SW-1:0]    ser_tx_data,
  input  logic             ser_rx_push,
  input  logic             ser_rx_phase,
  input  logic [SW-1:0]    ser_rx_data,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  output logic             irq
);
  // control state
  logic [THR_W-1:0] thr_code [NQ];
  logic             tx_dma_en, rx_dma_en;
  logic [SW-1:0]    last_tx;

  // decoded strobes
  logic ctl_wr, tx_wr, rx_rd, flag_wr, mask_wr;
  logic tx_clear, rx_clear;
  assign ctl_wr   = bus_wr && (bus_addr == OFS_CTRL);
  assign flag_wr  = bus_wr && (bus_addr == OFS_FLAGS);
  assign mask_wr  = bus_wr && (bus_addr == OFS_MASK);
  assign tx_wr    = bus_wr && (bus_addr == OFS_TXDAT);
  assign rx_rd    = bus_rd && (bus_addr == OFS_RXDAT);
  assign tx_clear = ctl_wr && bus_wdata[CTL_TXCLR];
  assign rx_clear = ctl_wr && bus_wdata[CTL_RXCLR];

  // steering
  logic tx_phase, rx_phase;
  logic tx_accept, rx_accept;

  // lane interconnect
  logic [NQ-1:0] q_push, q_pop, q_clear, q_full, q_empty, q_level, q_drop, q_miss;
  logic [SW-1:0] q_wdata [NQ];
  logic [SW-1:0] q_head  [NQ];

  always_comb begin
    q_push[Q_TXL] = tx_wr && !tx_phase;
    q_push[Q_TXR] = tx_wr &&  tx_phase;
    q_push[Q_RXL] = ser_rx_push && !ser_rx_phase;
    q_push[Q_RXR] = ser_rx_push &&  ser_rx_phase;
    q_pop[Q_TXL]  = ser_tx_pop && !ser_tx_phase;
    q_pop[Q_TXR]  = ser_tx_pop &&  ser_tx_phase;
    q_pop[Q_RXL]  = rx_rd && !rx_phase;
    q_pop[Q_RXR]  = rx_rd &&  rx_phase;
    q_clear       = {rx_clear, rx_clear, tx_clear, tx_clear};
    q_wdata[Q_TXL] = bus_wdata[SW-1:0];
    q_wdata[Q_TXR] = bus_wdata[SW-1:0];
    q_wdata[Q_RXL] = ser_rx_data;
    q_wdata[Q_RXR] = ser_rx_data;
  end

  generate
    for (genvar i = 0; i < NQ; i++) begin : g_lane
      ssf_lane #(.DEPTH(DEPTH), .SW(SW), .IS_TX(i < 2)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (q_clear[i]),
        .push      (q_push[i]),
        .push_data (q_wdata[i]),
        .pop       (q_pop[i]),
        .thr_code  (thr_code[i]),
        .head      (q_head[i]),
        .full      (q_full[i]),
        .empty     (q_empty[i]),
        .level     (q_level[i]),
        .push_drop (q_drop[i]),
        .pop_miss  (q_miss[i])
      );
    end
  endgenerate

  logic tx_sel_full, rx_sel_empty;
  assign tx_sel_full  = tx_phase ? q_full[Q_TXR]  : q_full[Q_TXL];
  assign rx_sel_empty = rx_phase ? q_empty[Q_RXR] : q_empty[Q_RXL];
  assign tx_accept    = tx_wr && !tx_sel_full;
  assign rx_accept    = rx_rd && !rx_sel_empty;

  ssf_steer u_tx_steer (
    .clk(clk), .rst_n(rst_n), .clear(tx_clear), .advance(tx_accept), .phase(tx_phase)
  );
  ssf_steer u_rx_steer (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .advance(rx_accept), .phase(rx_phase)
  );

  // control register and last transmit sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) thr_code[i] <= '0;
      tx_dma_en <= 1'b0;
      rx_dma_en <= 1'b0;
      last_tx   <= '0;
    end else begin
      if (ctl_wr) begin
        for (int i = 0; i < NQ; i++) thr_code[i] <= bus_wdata[4*i +: THR_W];
        tx_dma_en <= bus_wdata[CTL_TXDMA];
        rx_dma_en <= bus_wdata[CTL_RXDMA];
      end
      if (tx_accept && !tx_clear) last_tx <= bus_wdata[SW-1:0];
    end
  end

  // event vector, bit order fixed by the flag register layout
  logic [NFLAG-1:0] evt, flags, mask;
  assign evt = {
    q_drop[Q_RXR], q_drop[Q_RXL],
    q_level[Q_RXR], q_level[Q_RXL],
    q_miss[Q_TXR], q_miss[Q_TXL],
    q_level[Q_TXR], q_level[Q_TXL]
  };

  ssf_flags #(.N(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_evt   (evt),
    .w1c_en    (flag_wr),
    .w1c       (bus_wdata[NFLAG-1:0]),
    .mask_wr   (mask_wr),
    .mask_data (bus_wdata[NFLAG-1:0]),
    .flags     (flags),
    .mask      (mask),
    .irq       (irq)
  );

  assign tx_dma_req  = tx_dma_en && (q_level[Q_TXL] || q_level[Q_TXR]);
  assign rx_dma_req  = rx_dma_en && (q_level[Q_RXL] || q_level[Q_RXR]);
  assign ser_tx_data = ser_tx_phase ? q_head[Q_TXR] : q_head[Q_TXL];

  // read mux
  logic [SW-1:0] rx_head_sel;
  assign rx_head_sel = rx_phase ? q_head[Q_RXR] : q_head[Q_RXL];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        for (int i = 0; i < NQ; i++) bus_rdata[4*i +: THR_W] = thr_code[i];
        bus_rdata[CTL_TXDMA] = tx_dma_en;
        bus_rdata[CTL_RXDMA] = rx_dma_en;
      end
      OFS_STATUS: begin
        bus_rdata[17] = q_full[Q_TXL];
        bus_rdata[16] = q_full[Q_TXR];
        bus_rdata[1]  = q_empty[Q_RXL];
        bus_rdata[0]  = q_empty[Q_RXR];
      end
      OFS_FLAGS: bus_rdata[NFLAG-1:0] = flags;
      OFS_MASK:  bus_rdata[NFLAG-1:0] = mask;
      OFS_TXDAT: bus_rdata[SW-1:0]    = last_tx;
      OFS_RXDAT: bus_rdata[SW-1:0]    = rx_head_sel;
      default:   bus_rdata = '0;
    endcase
  end

  a_r3_drop_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_clear && (q_drop[Q_TXL] || q_drop[Q_TXR])) |=> $stable(tx_phase));

  a_r4_miss_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_clear && (q_miss[Q_RXL] || q_miss[Q_RXR])) |=> $stable(rx_phase));

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && (q_miss[Q_RXL] || q_miss[Q_RXR])) |-> (bus_rdata == '0));

  a_r11_last_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_accept && !tx_clear) |=> (bus_addr != OFS_TXDAT) || (bus_rdata[SW-1:0] == $past(bus_wdata[SW-1:0])));

endmodule

// File: tb/stereo_sample_fifo_bench.sv
module stereo_sample_fifo_bench;
  localparam int SW = 24;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          ser_tx_pop = 1'b0, ser_tx_phase = 1'b0;
  logic [SW-1:0] ser_tx_data;
  logic          ser_rx_push = 1'b0, ser_rx_phase = 1'b0;
  logic [SW-1:0] ser_rx_data = '0;
  logic          tx_dma_req, rx_dma_req, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stereo_sample_fifo #(.DEPTH(16), .SW(SW), .BUS_W(BW)) u_stereo_sample_fifo (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_tx_pop(ser_tx_pop), .ser_tx_phase(ser_tx_phase), .ser_tx_data(ser_tx_data),
    .ser_rx_push(ser_rx_push), .ser_rx_phase(ser_rx_phase), .ser_rx_data(ser_rx_data),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tx_pop(input logic ph, output logic [SW-1:0] d);
    @(negedge clk);
    ser_tx_phase = ph; ser_tx_pop = 1'b1;
    #1 d = ser_tx_data;
    @(negedge clk);
    ser_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input logic ph, input logic [SW-1:0] d);
    @(negedge clk);
    ser_rx_phase = ph; ser_rx_data = d; ser_rx_push = 1'b1;
    @(negedge clk);
    ser_rx_push = 1'b0;
  endtask

  task automatic flush_all();
    wr(3'd0, 32'h0030_0000);
    wr(3'd2, 32'h0000_00FF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd1, v); check("R1 status", v, 32'h0000_0003);
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd3, v); check("R1 mask", v, 32'h0);
    rd(3'd4, v); check("R11 txdata after reset", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 dma", {30'b0, tx_dma_req, rx_dma_req}, 32'h0);
    rd(3'd2, v); check("R7 idle flags", v, 32'h0000_0003);
  endtask

  task automatic t_alternate();
    logic [SW-1:0] d;
    flush_all();
    wr(3'd4, 32'hA1); wr(3'd4, 32'hB1); wr(3'd4, 32'hA2); wr(3'd4, 32'hB2);
    tx_pop(1'b0, d); check("R2 left first", d, 32'hA1);
    tx_pop(1'b1, d); check("R2 right first", d, 32'hB1);
    tx_pop(1'b0, d); check("R2 left second", d, 32'hA2);
    tx_pop(1'b1, d); check("R2 right second", d, 32'hB2);
  endtask

  task automatic t_full_drop();
    logic [31:0] v;
    logic [SW-1:0] d;
    flush_all();
    for (int i = 0; i < 16; i++) begin
      wr(3'd4, 32'h100 + i);
      wr(3'd4, 32'h200 + i);
    end
    rd(3'd1, v); check("R8 tx full bits", v, 32'h0003_0003);
    wr(3'd4, 32'hDEAD);
    rd(3'd4, v); check("R11 last accepted", v, 32'h20F);
    tx_pop(1'b0, d); check("R3 left head", d, 32'h100);
    rd(3'd1, v); check("R8 left not full", v, 32'h0001_0003);
    wr(3'd4, 32'hBEEF);   // phase still left after the drop
    wr(3'd4, 32'hCAFE);   // right full: dropped
    rd(3'd4, v); check("R11 last after drop", v, 32'hBEEF);
    for (int i = 1; i < 16; i++) begin
      tx_pop(1'b0, d); check("R3 left order", d, 32'h100 + i);
    end
    tx_pop(1'b0, d); check("R3 drop kept phase", d, 32'hBEEF);
    tx_pop(1'b1, d); check("R3 right untouched", d, 32'h200);
    tx_pop(1'b0, d); check("R6 underrun data", d, 32'h0);
    rd(3'd2, v); check("R6 underrun flag", v & 32'h4, 32'h4);
  endtask

  task automatic t_rx_order();
    logic [31:0] v;
    flush_all();
    rx_push(1'b0, 24'h11); rx_push(1'b1, 24'h22); rx_push(1'b0, 24'h33);
    rd(3'd1, v); check("R8 rx not empty", v, 32'h0);
    rd(3'd5, v); check("R4 first left", v, 32'h11);
    rd(3'd5, v); check("R4 then right", v, 32'h22);
    rd(3'd5, v); check("R4 left again", v, 32'h33);
    rd(3'd5, v); check("R4 empty reads zero", v, 32'h0);
    rx_push(1'b1, 24'h44);
    rd(3'd5, v); check("R4 miss kept phase", v, 32'h44);
    rd(3'd1, v); check("R8 rx empty", v, 32'h3);
    for (int i = 0; i < 17; i++) rx_push(1'b1, 24'h500 + i);
    rd(3'd2, v); check("R6 overrun right", v & 32'hC0, 32'h80);
    rd(3'd5, v); check("R4 left empty read", v, 32'h0);
  endtask

  task automatic t_threshold();
    logic [31:0] v;
    wr(3'd0, 32'h0030_0003);          // tx-left code 3 = 16 words
    wr(3'd4, 32'h77);
    wr(3'd2, 32'hFF);
    rd(3'd2, v); check("R5 tx 16-word level", v, 32'h02);
    wr(3'd0, 32'h0030_0100);          // rx-left code 1 = 4 words
    wr(3'd2, 32'hFF);
    for (int i = 0; i < 3; i++) rx_push(1'b0, 24'h60 + i);
    rd(3'd2, v); check("R5 rx below 4", v, 32'h03);
    rx_push(1'b0, 24'h63);
    rd(3'd2, v); check("R5 rx at 4", v, 32'h13);
    wr(3'd2, 32'h10);
    rd(3'd2, v); check("R7 event beats clear", v, 32'h13);
  endtask

  task automatic t_irq();
    flush_all();
    wr(3'd3, 32'h40);
    check("R7 irq low", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 17; i++) rx_push(1'b0, 24'h700 + i);
    @(negedge clk);
    check("R7 irq on overrun", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h40);
    @(negedge clk);
    check("R7 irq after w1c", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_dma();
    wr(3'd0, 32'h0032_0000);
    check("R10 rx empty no req", {30'b0, tx_dma_req, rx_dma_req}, 32'h0);
    rx_push(1'b0, 24'h1);
    rx_push(1'b1, 24'h2);
    check("R10 one each", {31'b0, rx_dma_req}, 32'h0);
    rx_push(1'b0, 24'h3);
    check("R10 rx req", {30'b0, tx_dma_req, rx_dma_req}, 32'h1);
    wr(3'd0, 32'h0001_0000);
    check("R10 tx req only", {30'b0, tx_dma_req, rx_dma_req}, 32'h2);
  endtask

  task automatic t_clear_ctrl();
    logic [31:0] v;
    logic [SW-1:0] d;
    flush_all();
    wr(3'd4, 32'h31);                 // phase now right
    wr(3'd0, 32'h0010_0000);          // flush tx
    rd(3'd1, v); check("R9 tx flushed", v & 32'h0003_0000, 32'h0);
    wr(3'd4, 32'h32);
    tx_pop(1'b0, d); check("R9 phase back to left", d, 32'h32);
    wr(3'd0, 32'hFFCF_FFFF);
    rd(3'd0, v); check("R12 ctrl readback", v, 32'h0003_7777);
    wr(3'd0, 32'h0033_0000);
    rd(3'd0, v); check("R9 clear bits read zero", v, 32'h0003_0000);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_alternate();
    t_full_drop();
    t_rx_order();
    t_threshold();
    t_irq();
    t_dma();
    t_clear_ctrl();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule